// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block sits between instruction fetch and the execution lanes of a multithreaded compute core. It keeps one buffered instruction per resident warp and, when the lanes are free, sends one of them to execution. An instruction may issue only when none of its registers is waiting for a result. The block tracks this with a pending bit for each register of each warp. The bit is set when an instruction that writes that register issues. It is cleared when the execution side reports that the value has been written back. Switching between warps costs nothing: any warp may issue in any issue window.

The lanes take four cycles to run one warp instruction, so a new issue can begin only every `ISSUE_GAP` cycles. A two-state machine controls this pacing. In `ST_PICK` the block issues as soon as some warp is eligible, and the issue moves it to `ST_HOLD`. In `ST_HOLD` it counts down, stays there while the count is non-zero, and returns to `ST_PICK` when the count reaches zero. Every cycle the block also names one warp whose slot is empty, so that fetch can refill it.

An instruction is packed as opcode, destination, source A and source B. Each buffered instruction carries a small saturating age counter. Older instructions win. A rotating pointer decides between instructions of equal age.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no instruction issues, no register is pending, and every slot is empty, so `fetch_req_valid` is 1 and `fetch_req_warp` is 0.
- R2: `fetch_req_warp` names the first empty slot found by scanning upward from a fetch pointer, wrapping after the last warp. In every cycle that shows a request, the fetch pointer moves to the warp after the one named.
- R3: A `fetch_valid` pulse fills the slot of `fetch_warp` only if that slot is empty at the clock edge. A fetch aimed at an occupied slot is dropped, and the buffered instruction is kept unchanged.
- R4: Issues are at least `ISSUE_GAP` (4) cycles apart. `issue_valid` is a one-cycle pulse in the cycle after the selecting edge, and it carries the warp number and the instruction fields.
- R5: An instruction is eligible only when its source A, source B and destination registers are all not pending for its own warp.
- R6: Issuing an instruction sets the pending bit of its destination register for that warp only. If a write-back to the same register arrives at the same edge, the set takes effect.
- R7: `wb_valid` with `wb_warp`/`wb_reg` clears that pending bit at the clock edge, and a warp blocked by that bit may be selected at the next edge.
- R8: Each buffered instruction has an age that starts at 0 when it is fetched and rises by 1, saturating at 3, at every issue from another warp. The eligible instruction with the highest age is selected.
- R9: Among eligible instructions of equal highest age, the first one found by scanning upward from the issue pointer is selected. After an issue the pointer moves to the warp that follows the issued one.
- R10: Issuing empties the warp's slot, which then becomes a candidate for a fetch request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetched instruction is presented |
| fetch_warp | input | 5 | Warp that owns the fetched instruction |
| fetch_op | input | 8 | Opcode of the fetched instruction |
| fetch_dst | input | 4 | Destination register |
| fetch_src_a | input | 4 | First source register |
| fetch_src_b | input | 4 | Second source register |
| wb_valid | input | 1 | A result was written back |
| wb_warp | input | 5 | Warp of the written-back result |
| wb_reg | input | 4 | Register that was written back |
| fetch_req_valid | output | 1 | Some slot is empty |
| fetch_req_warp | output | 5 | Warp whose slot should be refilled |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_warp | output | 5 | Warp of the issued instruction |
| issue_op | output | 8 | Opcode of the issued instruction |
| issue_dst | output | 4 | Destination register of the issued instruction |
| issue_src_a | output | 4 | First source of the issued instruction |
| issue_src_b | output | 4 | Second source of the issued instruction |

## Verification
The bench confines registers to a tiny range so that dependences on sources and on destinations are dense. A design that skipped the destination check would then issue over a pending write, and one that honoured write-backs a cycle late would issue one window after the reference. Some fetches are aimed on purpose at occupied slots; a design that overwrote a slot would issue an opcode the reference never buffered. Long runs with every slot full push ages to saturation, so a wrong age order or a wrong pointer update shows up as the wrong warp at issue. Runs where every warp stalls at once test whether the pointer and the hold count stay correct while nothing issues.

// File: rtl/ws_pkg.sv
package ws_pkg;
    typedef enum logic [0:0] {
        ST_PICK = 1'b0,
        ST_HOLD = 1'b1
    } issue_state_e;
endpackage

// File: rtl/ws_rot_pick.sv
// First set request found scanning upward from a start index, wrapping.
module ws_rot_pick #(
    parameter int N  = 24,
    parameter int IW = 5
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && req[(int'(start) + i) % N]) begin
                found = 1'b1;
                idx   = IW'((int'(start) + i) % N);
            end
        end
    end
endmodule

// File: rtl/ws_scoreboard.sv
// Pending-write bits, one per register per warp.
module ws_scoreboard #(
    parameter int NW = 24,
    parameter int NR = 16,
    parameter int WW = 5,
    parameter int RW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_en,
    input  logic [WW-1:0]          set_warp,
    input  logic [RW-1:0]          set_reg,
    input  logic                   clr_en,
    input  logic [WW-1:0]          clr_warp,
    input  logic [RW-1:0]          clr_reg,
    output logic [NW-1:0][NR-1:0]  pend
);
    logic clr_ok;
    assign clr_ok = clr_en && (int'(clr_warp) < NW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            if (clr_ok)
                pend[clr_warp][clr_reg] <= 1'b0;
            if (set_en)
                pend[set_warp][set_reg] <= 1'b1;
        end
    end

    // R5
    set_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !pend[set_warp][set_reg]);

    // R7
    clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ok && !(set_en && set_warp == clr_warp && set_reg == clr_reg))
        |=> !pend[$past(clr_warp)][$past(clr_reg)]);
endmodule

// File: rtl/ws_slot_bank.sv
// One instruction slot per warp with a saturating age.
module ws_slot_bank #(
    parameter int NW = 24,
    parameter int WW = 5,
    parameter int IW = 20,
    parameter int AW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [WW-1:0]         wr_warp,
    input  logic [IW-1:0]         wr_data,
    input  logic                  take_en,
    input  logic [WW-1:0]         take_warp,
    output logic [NW-1:0]         valid,
    output logic [NW-1:0][IW-1:0] data,
    output logic [NW-1:0][AW-1:0] age
);
    for (genvar w = 0; w < NW; w++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid[w] <= 1'b0;
                data[w]  <= '0;
                age[w]   <= '0;
            end else if (take_en && int'(take_warp) == w) begin
                valid[w] <= 1'b0;
            end else if (wr_en && int'(wr_warp) == w && !valid[w]) begin
                valid[w] <= 1'b1;
                data[w]  <= wr_data;
                age[w]   <= '0;
            end else if (take_en && valid[w] && age[w] != '1) begin
                age[w] <= age[w] + 1'b1;
            end
        end

        // R3
        occupied_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(wr_warp) == w && valid[w]) |=> data[w] == $past(data[w]));

        // R10
        take_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (take_en && int'(take_warp) == w) |=> !valid[w]);
    end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import ws_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int NUM_REGS  = 16,
    parameter int OP_W      = 8,
    parameter int ISSUE_GAP = 4,
    parameter int AGE_W     = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fetch_valid,
    input  logic [$clog2(NUM_WARPS)-1:0] fetch_warp,
    input  logic [OP_W-1:0]              fetch_op,
    input  logic [$clog2(NUM_REGS)-1:0]  fetch_dst,
    input  logic [$clog2(NUM_REGS)-1:0]  fetch_src_a,
    input  logic [$clog2(NUM_REGS)-1:0]  fetch_src_b,
    input  logic                         wb_valid,
    input  logic [$clog2(NUM_WARPS)-1:0] wb_warp,
    input  logic [$clog2(NUM_REGS)-1:0]  wb_reg,
    output logic                         fetch_req_valid,
    output logic [$clog2(NUM_WARPS)-1:0] fetch_req_warp,
    output logic                         issue_valid,
    output logic [$clog2(NUM_WARPS)-1:0] issue_warp,
    output logic [OP_W-1:0]              issue_op,
    output logic [$clog2(NUM_REGS)-1:0]  issue_dst,
    output logic [$clog2(NUM_REGS)-1:0]  issue_src_a,
    output logic [$clog2(NUM_REGS)-1:0]  issue_src_b
);
    localparam int WARP_W  = $clog2(NUM_WARPS);
    localparam int REG_W   = $clog2(NUM_REGS);
    localparam int INSTR_W = OP_W + 3 * REG_W;
    localparam int GAP_W   = (ISSUE_GAP > 2) ? $clog2(ISSUE_GAP) : 1;

    logic [NUM_WARPS-1:0]                slot_v;
    logic [NUM_WARPS-1:0][INSTR_W-1:0]   slot_d;
    logic [NUM_WARPS-1:0][AGE_W-1:0]     slot_age;
    logic [NUM_WARPS-1:0][NUM_REGS-1:0]  pend;
    logic [NUM_WARPS-1:0]                elig;
    logic [NUM_WARPS-1:0]                top_mask;
    logic [AGE_W-1:0]                    max_age;
    logic                                cand_found;
    logic [WARP_W-1:0]                   cand_warp;
    logic [WARP_W-1:0]                   rr_ptr;
    logic [WARP_W-1:0]                   fetch_ptr;
    logic                                fire;
    logic [REG_W-1:0]                    cand_dst;
    issue_state_e                        state, state_nx;
    logic [GAP_W-1:0]                    hold_cnt, hold_nx;

    // Slot storage and scoreboard
    ws_slot_bank #(.NW(NUM_WARPS), .WW(WARP_W), .IW(INSTR_W), .AW(AGE_W)) i_slots (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fetch_valid), .wr_warp(fetch_warp),
        .wr_data({fetch_op, fetch_dst, fetch_src_a, fetch_src_b}),
        .take_en(fire), .take_warp(cand_warp),
        .valid(slot_v), .data(slot_d), .age(slot_age)
    );

    assign cand_dst = slot_d[cand_warp][3*REG_W-1 -: REG_W];

    ws_scoreboard #(.NW(NUM_WARPS), .NR(NUM_REGS), .WW(WARP_W), .RW(REG_W)) i_sb (
        .clk(clk), .rst_n(rst_n),
        .set_en(fire), .set_warp(cand_warp), .set_reg(cand_dst),
        .clr_en(wb_valid), .clr_warp(wb_warp), .clr_reg(wb_reg),
        .pend(pend)
    );

    // Eligibility per warp
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
        logic [REG_W-1:0] d_r, a_r, b_r;
        assign d_r = slot_d[w][3*REG_W-1 -: REG_W];
        assign a_r = slot_d[w][2*REG_W-1 -: REG_W];
        assign b_r = slot_d[w][REG_W-1:0];
        assign elig[w] = slot_v[w] && !pend[w][d_r] && !pend[w][a_r] && !pend[w][b_r];
    end

    always_comb begin
        max_age = '0;
        for (int w = 0; w < NUM_WARPS; w++)
            if (elig[w] && slot_age[w] > max_age)
                max_age = slot_age[w];
    end

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_mask
        assign top_mask[w] = elig[w] && (slot_age[w] == max_age);
    end

    ws_rot_pick #(.N(NUM_WARPS), .IW(WARP_W)) i_issue_pick (
        .req(top_mask), .start(rr_ptr), .found(cand_found), .idx(cand_warp)
    );

    ws_rot_pick #(.N(NUM_WARPS), .IW(WARP_W)) i_fetch_pick (
        .req(~slot_v), .start(fetch_ptr), .found(fetch_req_valid), .idx(fetch_req_warp)
    );

    assign fire = (state == ST_PICK) && cand_found;

    // Pacing state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_PICK;
            hold_cnt <= '0;
        end else begin
            state    <= state_nx;
            hold_cnt <= hold_nx;
        end
    end

    always_comb begin
        state_nx = state;
        hold_nx  = hold_cnt;
        unique case (state)
            ST_PICK: begin
                if (fire) begin
                    state_nx = ST_HOLD;
                    hold_nx  = GAP_W'(ISSUE_GAP - 2);
                end
            end
            ST_HOLD: begin
                if (hold_cnt == '0)
                    state_nx = ST_PICK;
                else
                    hold_nx = hold_cnt - 1'b1;
            end
        endcase
    end

    // Outputs and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_valid <= 1'b0;
            issue_warp  <= '0;
            issue_op    <= '0;
            issue_dst   <= '0;
            issue_src_a <= '0;
            issue_src_b <= '0;
            rr_ptr      <= '0;
            fetch_ptr   <= '0;
        end else begin
            issue_valid <= fire;
            if (fire) begin
                issue_warp  <= cand_warp;
                {issue_op, issue_dst, issue_src_a, issue_src_b} <= slot_d[cand_warp];
                rr_ptr <= (cand_warp == WARP_W'(NUM_WARPS - 1)) ? '0 : cand_warp + 1'b1;
            end
            if (fetch_req_valid)
                fetch_ptr <= (fetch_req_warp == WARP_W'(NUM_WARPS - 1)) ? '0
                                                                        : fetch_req_warp + 1'b1;
        end
    end

    // Checker state: cycles since the last issue pulse
    int chk_since;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chk_since <= ISSUE_GAP;
        else if (issue_valid)
            chk_since <= 1;
        else if (chk_since < ISSUE_GAP)
            chk_since <= chk_since + 1;
    end

    // R4
    issue_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> chk_since >= ISSUE_GAP);

    // R6
    dst_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> pend[issue_warp][issue_dst]);

    // R2
    fetch_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_valid |-> !slot_v[fetch_req_warp]);

    // R10
    issued_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !slot_v[issue_warp]);
endmodule

// File: tb/test_warp_issue_sched.sv
module test_warp_issue_sched;
    localparam int NW  = 24;
    localparam int NR  = 16;
    localparam int GAP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fetch_valid = 1'b0;
    logic [4:0] fetch_warp = '0;
    logic [7:0] fetch_op = '0;
    logic [3:0] fetch_dst = '0, fetch_src_a = '0, fetch_src_b = '0;
    logic       wb_valid = 1'b0;
    logic [4:0] wb_warp = '0;
    logic [3:0] wb_reg = '0;
    logic       fetch_req_valid, issue_valid;
    logic [4:0] fetch_req_warp, issue_warp;
    logic [7:0] issue_op;
    logic [3:0] issue_dst, issue_src_a, issue_src_b;

    always #4 clk = ~clk;

    warp_issue_sched i_warp_issue_sched (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_warp(fetch_warp), .fetch_op(fetch_op),
        .fetch_dst(fetch_dst), .fetch_src_a(fetch_src_a), .fetch_src_b(fetch_src_b),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .fetch_req_valid(fetch_req_valid), .fetch_req_warp(fetch_req_warp),
        .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_op(issue_op),
        .issue_dst(issue_dst), .issue_src_a(issue_src_a), .issue_src_b(issue_src_b)
    );

    // Behavioural reference model
    bit m_v[NW];
    int m_op[NW], m_dst[NW], m_sa[NW], m_sb[NW], m_age[NW];
    bit m_pend[NW][NR];
    int m_rr, m_fp, m_cool;
    bit o_v;
    int o_w, o_op, o_dst, o_sa, o_sb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    string phase = "R1";

    function automatic int model_fetch_req();
        for (int i = 0; i < NW; i++)
            if (!m_v[(m_fp + i) % NW]) return (m_fp + i) % NW;
        return -1;
    endfunction

    function automatic bit model_elig(int w);
        return m_v[w] && !m_pend[w][m_dst[w]] && !m_pend[w][m_sa[w]] && !m_pend[w][m_sb[w]];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NW; w++) begin
                m_v[w] = 0; m_age[w] = 0;
                for (int r = 0; r < NR; r++) m_pend[w][r] = 0;
            end
            m_rr = 0; m_fp = 0; m_cool = 0; o_v = 0;
        end else begin
            int best, bage, fr;
            bit old_v[NW];
            best = -1; bage = -1;
            for (int w = 0; w < NW; w++) old_v[w] = m_v[w];
            if (m_cool == 0)
                for (int i = 0; i < NW; i++) begin
                    int w;
                    w = (m_rr + i) % NW;
                    if (model_elig(w) && m_age[w] > bage) begin best = w; bage = m_age[w]; end
                end
            fr = model_fetch_req();
            if (best >= 0) begin
                o_v = 1; o_w = best; o_op = m_op[best]; o_dst = m_dst[best];
                o_sa = m_sa[best]; o_sb = m_sb[best];
                m_v[best] = 0;
                for (int w = 0; w < NW; w++)
                    if (w != best && old_v[w] && m_age[w] < 3) m_age[w]++;
                m_rr = (best + 1) % NW;
                m_cool = GAP - 1;
            end else begin
                o_v = 0;
                if (m_cool > 0) m_cool--;
            end
            if (wb_valid && int'(wb_warp) < NW) m_pend[wb_warp][wb_reg] = 0;
            if (best >= 0) m_pend[best][o_dst] = 1;
            if (fetch_valid && int'(fetch_warp) < NW && !old_v[fetch_warp]) begin
                m_v[fetch_warp] = 1; m_op[fetch_warp] = fetch_op; m_dst[fetch_warp] = fetch_dst;
                m_sa[fetch_warp] = fetch_src_a; m_sb[fetch_warp] = fetch_src_b;
                m_age[fetch_warp] = 0;
            end
            if (fr >= 0) m_fp = (fr + 1) % NW;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, phase, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int fr;
        fr = model_fetch_req();
        check(issue_valid == o_v, "R4", "issue_valid", int'(issue_valid), int'(o_v));
        if (o_v && issue_valid) begin
            check(int'(issue_warp) == o_w, phase, "issue_warp", int'(issue_warp), o_w);
            check(int'(issue_op) == o_op, phase, "issue_op", int'(issue_op), o_op);
            check(int'(issue_dst) == o_dst, phase, "issue_dst", int'(issue_dst), o_dst);
            check(int'(issue_src_a) == o_sa && int'(issue_src_b) == o_sb, phase, "issue_src",
                  int'({issue_src_a, issue_src_b}), o_sa * 16 + o_sb);
        end
        check(fetch_req_valid == (fr >= 0), "R2", "fetch_req_valid", int'(fetch_req_valid), int'(fr >= 0));
        if (fr >= 0)
            check(int'(fetch_req_warp) == fr, "R2", "fetch_req_warp", int'(fetch_req_warp), fr);
    endtask

    task automatic run_phase(string tag, int cycles, int p_fetch, int p_wrong, int reg_max, int p_wb);
        phase = tag;
        for (int c = 0; c < cycles; c++) begin
            int q[$];
            @(negedge clk);
            compare_all();
            fetch_valid = 1'b0;
            wb_valid    = 1'b0;
            if ($urandom_range(99, 0) < p_fetch) begin
                fetch_valid = 1'b1;
                if ($urandom_range(99, 0) < p_wrong) fetch_warp = 5'($urandom_range(NW - 1, 0));
                else fetch_warp = fetch_req_warp;
                fetch_op    = 8'($urandom);
                fetch_dst   = 4'($urandom_range(reg_max, 0));
                fetch_src_a = 4'($urandom_range(reg_max, 0));
                fetch_src_b = 4'($urandom_range(reg_max, 0));
            end
            for (int w = 0; w < NW; w++)
                for (int r = 0; r < NR; r++)
                    if (m_pend[w][r]) q.push_back(w * NR + r);
            if (q.size() > 0 && $urandom_range(99, 0) < p_wb) begin
                int pick;
                pick = q[$urandom_range(q.size() - 1, 0)];
                wb_valid = 1'b1;
                wb_warp  = 5'(pick / NR);
                wb_reg   = 4'(pick % NR);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog [%s] run did not end actual=1 expected=0", phase);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the ports
        check(issue_valid == 1'b0, "R1", "issue_valid after reset", int'(issue_valid), 0);
        check(fetch_req_valid == 1'b1, "R1", "fetch_req_valid after reset", int'(fetch_req_valid), 1);
        check(fetch_req_warp == 5'd0, "R1", "fetch_req_warp after reset", int'(fetch_req_warp), 0);
        run_phase("R2", 30, 0, 0, 15, 0);
        run_phase("R3", 300, 90, 30, 15, 60);
        run_phase("R5", 400, 80, 10, 3, 25);
        run_phase("R6", 300, 90, 10, 1, 40);
        run_phase("R7", 300, 90, 0, 2, 100);
        run_phase("R8", 500, 100, 0, 15, 90);
        run_phase("R9", 400, 100, 0, 7, 70);
        run_phase("R10", 200, 30, 0, 15, 80);
        @(negedge clk);
        compare_all();
        finish_run();
    end
endmodule